// File: doc/BRIEF.md
# Hardware Thread Lock Table

This block arbitrates mutual exclusion among the hardware threads of a multithreaded core. A thread that wants a shared object sends a lock request with its thread number and the object's base address. The address alone identifies the lock, so the size of the object plays no part. If no entry holds that address, the block opens an entry and the requester becomes its owner. If another thread already owns it, the requester is marked stalled and joins that entry's waiting line in arrival order.

When the owner sends an unlock, the entry is not opened up for a fresh contest. Ownership passes straight to the thread that has waited longest, and the block sends a wake pulse naming that thread and clears its stall bit. An entry with nobody waiting is invalidated and can be reused. If a request names a new address while every entry is in use, the requester is stalled and a full flag is raised. The next time an entry frees, every thread blocked this way is released so that it can issue its request again. All outputs are registered and appear one cycle after the request.

Top module: `hw_lock_table`

## Requirements
- R1: After reset, no entry is valid, `stall_mask` is all zero, and `lock_ok`, `wake_vld`, `unlock_err` and `table_full` are low.
- R2: A lock request for an address held by no entry claims a free entry for the requester. `lock_ok` pulses in the next cycle and the requester's stall bit stays clear.
- R3: Locks are matched on the full address only. Requests to different addresses never conflict, and requests to equal addresses always do.
- R4: A lock request for an address owned by a different thread sets bit `lock_tid` of `stall_mask` in the next cycle. `lock_ok` stays low.
- R5: A lock request from the current owner for an address it already holds pulses `lock_ok` and leaves the entry and the stall mask unchanged.
- R6: An unlock from the owner of an entry that has waiters makes the oldest waiter the new owner. In the next cycle `wake_vld` pulses, `wake_tid` names that thread, and its stall bit is clear.
- R7: Waiters on one address receive ownership in the order their lock requests arrived.
- R8: An unlock from the owner of an entry with no waiters invalidates the entry. No wake pulse is sent, and a later lock on that address from any thread succeeds at once.
- R9: An unlock from a thread that does not own the addressed entry, or for an address that no entry holds, changes nothing and pulses `unlock_err` in the next cycle.
- R10: A lock request for a new address while all entries are valid stalls the requester and sets `table_full`. When an entry is next invalidated, `table_full` drops and the stall bits of all threads blocked this way clear without a wake pulse.
- R11: When a lock and an unlock arrive in the same cycle, the unlock is applied first. The lock then sees the entry as freed, or sees the new owner and the shortened waiting line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lock_vld | input | 1 | Lock request valid |
| lock_tid | input | TW | Thread number of the lock requester |
| lock_addr | input | AW | Base address to lock |
| unlock_vld | input | 1 | Unlock request valid |
| unlock_tid | input | TW | Thread number of the unlocking thread |
| unlock_addr | input | AW | Base address to unlock |
| lock_ok | output | 1 | Pulse: the lock request of the previous cycle was granted |
| wake_vld | output | 1 | Pulse: a waiter was handed ownership |
| wake_tid | output | TW | Thread number woken by `wake_vld` |
| unlock_err | output | 1 | Pulse: the previous unlock was rejected |
| stall_mask | output | NTHR | One bit per thread, set while that thread is stalled |
| table_full | output | 1 | High while threads are blocked because no entry was free |

## Verification
The assertions assume that a stalled thread issues no requests. They also assume that no thread asks to lock an address it is already waiting on. Together these keep every waiting line shorter than the thread count, and they mean the same thread never appears twice in one line. The directed tasks only send requests from threads whose stall bit is clear in the expected model. A thread blocked by a full table is held back until the bench has seen its stall bit clear, and only then does it retry.

// File: rtl/lkt_pkg.sv
package lkt_pkg;

  // Classification of a lock request after the unlock of the same cycle
  typedef enum logic [2:0] {
    LK_NONE  = 3'd0,
    LK_NEW   = 3'd1,
    LK_REOWN = 3'd2,
    LK_WAIT  = 3'd3,
    LK_FULL  = 3'd4
  } lk_kind_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  function automatic lk_kind_e lk_classify(input logic vld, input logic hit,
                                           input logic is_owner, input logic any_free);
    if (!vld)          return LK_NONE;
    if (hit)           return is_owner ? LK_REOWN : LK_WAIT;
    return any_free ? LK_NEW : LK_FULL;
  endfunction

endpackage

// File: rtl/lkt_pick.sv
module lkt_pick #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/lkt_entry.sv
module lkt_entry #(
  parameter int AW   = 32,
  parameter int NTHR = 8,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int QD = (NTHR > 1) ? NTHR - 1 : 1,
  localparam int CW = $clog2(QD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          release_i,
  input  logic          alloc_i,
  input  logic          enq_i,
  input  logic [TW-1:0] tid_i,
  input  logic [AW-1:0] addr_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [TW-1:0] owner_o,
  output logic [TW-1:0] head_o,
  output logic          has_wait_o,
  output logic          pv_valid_o,
  output logic [TW-1:0] pv_owner_o
);
  logic                   v_q, v_r, v_n;
  logic [AW-1:0]          a_q, a_n;
  logic [TW-1:0]          o_q, o_r, o_n;
  logic [QD-1:0][TW-1:0]  q_q, q_r, q_n;
  logic [CW-1:0]          c_q, c_r, c_n;

  // stage 1: apply release (handoff or invalidate)
  always_comb begin
    v_r = v_q;
    o_r = o_q;
    q_r = q_q;
    c_r = c_q;
    if (release_i) begin
      if (c_q != '0) begin
        o_r = q_q[0];
        for (int i = 0; i < QD - 1; i++) q_r[i] = q_q[i+1];
        q_r[QD-1] = '0;
        c_r = c_q - CW'(1);
      end else begin
        v_r = 1'b0;
      end
    end
  end

  // stage 2: apply allocation or enqueue on the post-release view
  always_comb begin
    v_n = v_r;
    a_n = a_q;
    o_n = o_r;
    q_n = q_r;
    c_n = c_r;
    if (alloc_i) begin
      v_n = 1'b1;
      a_n = addr_i;
      o_n = tid_i;
      c_n = '0;
    end
    if (enq_i) begin
      for (int i = 0; i < QD; i++) begin
        if (CW'(i) == c_r) q_n[i] = tid_i;
      end
      if (c_r < CW'(QD)) c_n = c_r + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      a_q <= '0;
      o_q <= '0;
      q_q <= '0;
      c_q <= '0;
    end else begin
      v_q <= v_n;
      a_q <= a_n;
      o_q <= o_n;
      q_q <= q_n;
      c_q <= c_n;
    end
  end

  assign valid_o    = v_q;
  assign addr_o     = a_q;
  assign owner_o    = o_q;
  assign head_o     = q_q[0];
  assign has_wait_o = (c_q != '0);
  assign pv_valid_o = v_r;
  assign pv_owner_o = o_r;

  a_r7_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    c_q <= CW'(QD));
  a_r8_free_has_no_waiters: assert property (@(posedge clk) disable iff (!rst_n)
    !v_q |-> (c_q == '0));
  a_r6_handoff_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (release_i && c_q != '0 && !enq_i) |=> (c_q == $past(c_q) - CW'(1)));
endmodule

// File: rtl/hw_lock_table.sv
module hw_lock_table
  import lkt_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NTHR = 8,
  parameter int NENT = 8,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int EW = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lock_vld,
  input  logic [TW-1:0]   lock_tid,
  input  logic [AW-1:0]   lock_addr,
  input  logic            unlock_vld,
  input  logic [TW-1:0]   unlock_tid,
  input  logic [AW-1:0]   unlock_addr,
  output logic            lock_ok,
  output logic            wake_vld,
  output logic [TW-1:0]   wake_tid,
  output logic            unlock_err,
  output logic [NTHR-1:0] stall_mask,
  output logic            table_full
);
  // per-entry views
  logic [NENT-1:0]          e_valid, e_pv_valid, e_wait;
  logic [NENT-1:0][AW-1:0]  e_addr;
  logic [NENT-1:0][TW-1:0]  e_owner, e_head, e_pv_owner;
  logic [NENT-1:0]          e_release, e_alloc, e_enq;

  // lookup vectors
  logic [NENT-1:0] u_hitv, l_hitv, freev;
  logic [EW-1:0]   u_idx, l_idx, f_idx;
  logic            u_hit, l_hit, f_any;

  // named events
  logic            ev_unlock_ok, ev_handoff, ev_free, ev_unlock_bad;
  logic [TW-1:0]   ev_wake_tid;
  lk_kind_e        ev_lock;

  // registered state
  logic [NTHR-1:0] stall_q, stall_n, fullw_q, fullw_n;
  logic            ok_q, wake_q, err_q, full_q;
  logic [TW-1:0]   wtid_q;

  genvar g;
  generate
    for (g = 0; g < NENT; g++) begin : g_ent
      assign u_hitv[g]    = e_valid[g] && (e_addr[g] == unlock_addr);
      assign l_hitv[g]    = e_pv_valid[g] && (e_addr[g] == lock_addr);
      assign freev[g]     = !e_pv_valid[g];
      assign e_release[g] = ev_unlock_ok && u_hitv[g];
      assign e_alloc[g]   = (ev_lock == LK_NEW) && (f_idx == EW'(g));
      assign e_enq[g]     = (ev_lock == LK_WAIT) && l_hitv[g];

      lkt_entry #(.AW(AW), .NTHR(NTHR)) u_ent (
        .clk        (clk),
        .rst_n      (rst_n),
        .release_i  (e_release[g]),
        .alloc_i    (e_alloc[g]),
        .enq_i      (e_enq[g]),
        .tid_i      (lock_tid),
        .addr_i     (lock_addr),
        .valid_o    (e_valid[g]),
        .addr_o     (e_addr[g]),
        .owner_o    (e_owner[g]),
        .head_o     (e_head[g]),
        .has_wait_o (e_wait[g]),
        .pv_valid_o (e_pv_valid[g]),
        .pv_owner_o (e_pv_owner[g])
      );
    end
  endgenerate

  lkt_pick #(.W(NENT)) u_pick_unl  (.vec_i(u_hitv), .idx_o(u_idx), .any_o(u_hit));
  lkt_pick #(.W(NENT)) u_pick_lock (.vec_i(l_hitv), .idx_o(l_idx), .any_o(l_hit));
  lkt_pick #(.W(NENT)) u_pick_free (.vec_i(freev),  .idx_o(f_idx), .any_o(f_any));

  // unlock side sees the current table
  assign ev_unlock_ok  = unlock_vld && u_hit && (e_owner[u_idx] == unlock_tid);
  assign ev_unlock_bad = unlock_vld && !ev_unlock_ok;
  assign ev_handoff    = ev_unlock_ok && e_wait[u_idx];
  assign ev_free       = ev_unlock_ok && !e_wait[u_idx];
  assign ev_wake_tid   = e_head[u_idx];

  // lock side sees the table after this cycle's unlock
  assign ev_lock = lk_classify(lock_vld, l_hit, e_pv_owner[l_idx] == lock_tid, f_any);

  always_comb begin
    stall_n = stall_q;
    fullw_n = fullw_q;
    if (ev_handoff) stall_n[ev_wake_tid] = 1'b0;
    if (ev_free) begin
      stall_n = stall_n & ~fullw_q;
      fullw_n = '0;
    end
    if (ev_lock == LK_WAIT || ev_lock == LK_FULL) stall_n[lock_tid] = 1'b1;
    if (ev_lock == LK_FULL) fullw_n[lock_tid] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= '0;
      fullw_q <= '0;
      ok_q    <= 1'b0;
      wake_q  <= 1'b0;
      wtid_q  <= '0;
      err_q   <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      stall_q <= stall_n;
      fullw_q <= fullw_n;
      ok_q    <= (ev_lock == LK_NEW) || (ev_lock == LK_REOWN);
      wake_q  <= ev_handoff;
      wtid_q  <= ev_handoff ? ev_wake_tid : wtid_q;
      err_q   <= ev_unlock_bad;
      full_q  <= |fullw_n;
    end
  end

  assign lock_ok    = ok_q;
  assign wake_vld   = wake_q;
  assign wake_tid   = wtid_q;
  assign unlock_err = err_q;
  assign stall_mask = stall_q;
  assign table_full = full_q;

  a_r6_woken_not_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> !stall_q[wtid_q]);
  a_r2_granted_not_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> !stall_q[$past(lock_tid)]);
  a_r4_waiter_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lock == LK_WAIT) |=> stall_q[$past(lock_tid)]);
  a_r10_full_implies_stall: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (stall_q != '0));
  a_r9_reject_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !wake_q);
  a_r11_free_then_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_free && lock_vld && lock_addr == unlock_addr) |-> (ev_lock == LK_NEW));
endmodule

// File: tb/hw_lock_table_tb.sv
module hw_lock_table_tb;
  localparam int AW = 32, NTHR = 8, NENT = 8, TW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lock_vld = 1'b0, unlock_vld = 1'b0;
  logic [TW-1:0] lock_tid = '0, unlock_tid = '0;
  logic [AW-1:0] lock_addr = '0, unlock_addr = '0;
  logic lock_ok, wake_vld, unlock_err, table_full;
  logic [TW-1:0] wake_tid;
  logic [NTHR-1:0] stall_mask;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hw_lock_table #(.AW(AW), .NTHR(NTHR), .NENT(NENT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .lock_vld(lock_vld), .lock_tid(lock_tid), .lock_addr(lock_addr),
    .unlock_vld(unlock_vld), .unlock_tid(unlock_tid), .unlock_addr(unlock_addr),
    .lock_ok(lock_ok), .wake_vld(wake_vld), .wake_tid(wake_tid),
    .unlock_err(unlock_err), .stall_mask(stall_mask), .table_full(table_full)
  );

  function automatic logic [AW-1:0] own_addr(input int t);
    return 32'h0000_1000 + 32'(t) * 32'h10;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one cycle of requests; outputs are examined at the next falling edge
  task automatic cyc(input logic lv, input int lt, input logic [AW-1:0] la,
                     input logic uv, input int ut, input logic [AW-1:0] ua);
    @(negedge clk);
    lock_vld = lv; lock_tid = TW'(lt); lock_addr = la;
    unlock_vld = uv; unlock_tid = TW'(ut); unlock_addr = ua;
    @(negedge clk);
    lock_vld = 1'b0; unlock_vld = 1'b0;
  endtask

  task automatic lk(input int t, input logic [AW-1:0] a);
    cyc(1'b1, t, a, 1'b0, 0, '0);
  endtask

  task automatic ul(input int t, input logic [AW-1:0] a);
    cyc(1'b0, 0, '0, 1'b1, t, a);
  endtask

  task automatic t_reset;
    chk("R1", "stall_mask", 32'(stall_mask), 0);
    chk("R1", "table_full", 32'(table_full), 0);
    chk("R1", "pulses", {29'd0, lock_ok, wake_vld, unlock_err}, 0);
  endtask

  task automatic t_acquire_and_queue;
    lk(0, 32'h100);
    chk("R2", "lock_ok on free address", 32'(lock_ok), 1);
    chk("R2", "stall after acquire", 32'(stall_mask), 0);
    lk(0, 32'h100);
    chk("R5", "owner relock ok", 32'(lock_ok), 1);
    chk("R5", "owner relock stall", 32'(stall_mask), 0);
    lk(1, 32'h100);
    chk("R4", "contender lock_ok", 32'(lock_ok), 0);
    chk("R4", "contender stalled", 32'(stall_mask), 32'h02);
    lk(2, 32'h100);
    lk(3, 32'h100);
    chk("R4", "three waiters", 32'(stall_mask), 32'h0E);
    lk(4, 32'h104);
    chk("R3", "neighbour address independent", 32'(lock_ok), 1);
    chk("R3", "stall unchanged", 32'(stall_mask), 32'h0E);
  endtask

  task automatic t_bad_unlock;
    ul(1, 32'h100);
    chk("R9", "non-owner unlock err", 32'(unlock_err), 1);
    chk("R9", "non-owner unlock no wake", 32'(wake_vld), 0);
    chk("R9", "stall kept", 32'(stall_mask), 32'h0E);
    ul(0, 32'h200);
    chk("R9", "unknown address err", 32'(unlock_err), 1);
    // owner still holds: its relock is still granted
    lk(0, 32'h100);
    chk("R9", "owner unchanged", 32'(lock_ok), 1);
  endtask

  task automatic t_handoff_order;
    ul(0, 32'h100);
    chk("R6", "wake pulse", 32'(wake_vld), 1);
    chk("R7", "first waiter woken", 32'(wake_tid), 1);
    chk("R6", "woken unstalled", 32'(stall_mask), 32'h0C);
    ul(1, 32'h100);
    chk("R7", "second waiter woken", 32'(wake_tid), 2);
    chk("R7", "stall after second", 32'(stall_mask), 32'h08);
    ul(2, 32'h100);
    chk("R7", "third waiter woken", 32'(wake_tid), 3);
    chk("R6", "no stalls left", 32'(stall_mask), 0);
    ul(3, 32'h100);
    chk("R8", "last release no wake", 32'(wake_vld), 0);
    chk("R8", "last release no err", 32'(unlock_err), 0);
    lk(5, 32'h100);
    chk("R8", "freed address reusable", 32'(lock_ok), 1);
    ul(5, 32'h100);
    ul(4, 32'h104);
    chk("R8", "clean release", 32'(unlock_err), 0);
  endtask

  task automatic t_full_table;
    for (int t = 0; t < NTHR; t++) begin
      lk(t, own_addr(t));
      chk("R2", "fill entry", 32'(lock_ok), 1);
    end
    lk(0, 32'h9000);
    chk("R10", "full request not granted", 32'(lock_ok), 0);
    chk("R10", "full flag", 32'(table_full), 1);
    chk("R10", "full requester stalled", 32'(stall_mask), 32'h01);
    ul(1, own_addr(1));
    chk("R10", "full flag drops", 32'(table_full), 0);
    chk("R10", "blocked thread released", 32'(stall_mask), 0);
    chk("R10", "release not a wake", 32'(wake_vld), 0);
    lk(0, 32'h9000);
    chk("R10", "retry granted", 32'(lock_ok), 1);
  endtask

  task automatic t_same_cycle;
    // free and reacquire in one cycle
    cyc(1'b1, 3, own_addr(2), 1'b1, 2, own_addr(2));
    chk("R11", "lock after same-cycle free", 32'(lock_ok), 1);
    chk("R11", "no wake on free", 32'(wake_vld), 0);
    // full table, entry freed in the same cycle as a new address arrives
    cyc(1'b1, 1, 32'hA000, 1'b1, 4, own_addr(4));
    chk("R11", "new address takes freed entry", 32'(lock_ok), 1);
    chk("R11", "table not full", 32'(table_full), 0);
    // handoff and enqueue together
    lk(6, own_addr(5));
    chk("R4", "waiter on thread 5 lock", 32'(stall_mask), 32'h40);
    cyc(1'b1, 7, own_addr(5), 1'b1, 5, own_addr(5));
    chk("R11", "handoff wakes 6", 32'(wake_tid), 6);
    chk("R11", "late arrival queued", 32'(stall_mask), 32'h80);
    ul(6, own_addr(5));
    chk("R7", "queued arrival woken next", 32'(wake_tid), 7);
    chk("R7", "no stalls", 32'(stall_mask), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_acquire_and_queue;
    t_bad_unlock;
    t_handoff_order;
    t_full_table;
    t_same_cycle;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule